// File: doc/BRIEF.md
# Double-Buffered 16-bit Pulse Generator Timer

This block produces a rectangular wave on one output pin from a 16-bit up counter and two compare values. The period value ends each cycle: when the counter reaches it on a counting tick, the counter returns to zero and a one-clock interrupt pulse follows. The duty value places the second edge inside the period. An output flip-flop inverts on either match, so each period can carry two edges. Software can also force the flip-flop to a known level before starting.

The counting tick comes from one of three prescaled clock enables or from rising edges on an external count pin. The duty value can be double buffered. With the buffer enabled, a new duty value written while the timer runs waits in a holding register. It moves to the active compare on the same edge that clears the counter, so it applies to a whole period.

A small state machine has two states. ST_STOP holds the counter at zero and suppresses all matches. ST_RUN lets the counter advance. The GO transition (ST_STOP to ST_RUN) happens on a control write with the run bit set. The HALT transition (ST_RUN to ST_STOP) happens on a control write with the run bit clear. Other writes leave the state unchanged.

Top module: `ppg_timer`

## Requirements
- R1: After reset the output is 0, the interrupt is 0, the state is ST_STOP, both toggle enables and the buffer are off, the tick source is the divide-by-1 enable, and the compare values are 0.
- R2: In ST_RUN the counter advances by one on each tick. The tick source is set by address 1, bits [1:0]: 0 selects tick_div1, 1 selects tick_div4, 2 selects tick_div16, and 3 selects rising edges of ext_cnt. The period in clocks is therefore the tick spacing times (period value + 1).
- R3: When the counter equals the period value (address 4) on a tick, the counter is 0 after that edge. If the period toggle is enabled (address 2, bit 1), the output inverts on that edge. Starting from count 0, this edge falls P+1 ticks after the start.
- R4: period_irq is high for exactly the one clock that follows each period-match edge.
- R5: If the duty toggle is enabled (address 2, bit 0), a tick with the counter equal to the active duty value inverts the output. Starting from count 0, this happens D+1 ticks after the start. A toggle that is disabled leaves the output unchanged at that match.
- R6: If the duty value is greater than or equal to the period value, the output changes only at period matches.
- R7: Address 0, bit 1 enables the duty buffer. When it is off, a duty write (address 3) sets the active duty value on the next edge, even while the counter runs. When it is on, a duty write only fills the holding register. The active value takes it on the next period-match edge and keeps it for the whole following period.
- R8: Address 0, bit 0 is the run bit, and writing it moves between ST_STOP and ST_RUN. In ST_STOP the counter is held at 0, no match or interrupt occurs, and the output keeps its level. A restart counts from 0.
- R9: The force field at address 2, bits [3:2], sets the output on the write edge. The value 1 forces 0 and the value 2 forces 1. A force takes priority over a toggle in the same cycle. The values 0 and 3 leave the output alone.
- R10: The register addresses are: 0 for control (run, buffer enable), 1 for tick source, 2 for flip-flop control, 3 for duty and 4 for period. A write takes effect on the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| tick_div1 | input | 1 | Divide-by-1 prescaler enable |
| tick_div4 | input | 1 | Divide-by-4 prescaler enable |
| tick_div16 | input | 1 | Divide-by-16 prescaler enable |
| ext_cnt | input | 1 | External count input, counted on rising edges |
| ppg_out | output | 1 | Pulse output flip-flop |
| period_irq | output | 1 | One-clock pulse after each period match |

## Verification
Every cycle, the assertions check the following: the counter only steps by one, holds, or returns to zero. It is zero whenever the interrupt fires and zero after a cycle in ST_STOP. The output never changes without a match or a force, and a force wins. The active duty value stays unchanged between period matches while the buffer is enabled. Several things need the bench's scenarios: the exact cycle of every output edge and interrupt, the deferred take-over of a buffered duty write, the immediate effect of an unbuffered one, the duty-above-period case, and the interrupt spacing for each tick source.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        SRC_DIV1  = 2'd0,
        SRC_DIV4  = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_EXT   = 2'd3
    } tick_src_e;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SRC  = 3'd1;
    localparam logic [ADDR_W-1:0] A_FFC  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DUTY = 3'd3;
    localparam logic [ADDR_W-1:0] A_PER  = 3'd4;

    localparam logic [1:0] FRC_LOW  = 2'd1;
    localparam logic [1:0] FRC_HIGH = 2'd2;

endpackage

// File: rtl/ppg_tick_sel.sv
module ppg_tick_sel
    import ppg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tick_src_e src,
    input  logic      en_div1,
    input  logic      en_div4,
    input  logic      en_div16,
    input  logic      ext_in,
    output logic      tick
);

    logic ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_in;
    end

    always_comb begin
        unique case (src)
            SRC_DIV1:  tick = en_div1;
            SRC_DIV4:  tick = en_div4;
            SRC_DIV16: tick = en_div16;
            SRC_EXT:   tick = ext_in & ~ext_q;
        endcase
    end

endmodule

// File: rtl/ppg_regs.sv
module ppg_regs
    import ppg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              per_hit,
    output logic              buf_en,
    output tick_src_e         src,
    output logic              tog_duty,
    output logic              tog_per,
    output logic              frc_lo,
    output logic              frc_hi,
    output logic [CNT_W-1:0]  duty_act,
    output logic [CNT_W-1:0]  per_val
);

    logic [CNT_W-1:0] duty_buf;
    logic             ffc_wr;

    assign ffc_wr = wr_en && (wr_addr == A_FFC);
    assign frc_lo = ffc_wr && (wr_data[3:2] == FRC_LOW);
    assign frc_hi = ffc_wr && (wr_data[3:2] == FRC_HIGH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_en   <= 1'b0;
            src      <= SRC_DIV1;
            tog_duty <= 1'b0;
            tog_per  <= 1'b0;
            duty_buf <= '0;
            duty_act <= '0;
            per_val  <= '0;
        end else begin
            if (buf_en && per_hit) duty_act <= duty_buf;
            if (wr_en) begin
                case (wr_addr)
                    A_CTRL: buf_en <= wr_data[1];
                    A_SRC:  src    <= tick_src_e'(wr_data[1:0]);
                    A_FFC: begin
                        tog_duty <= wr_data[0];
                        tog_per  <= wr_data[1];
                    end
                    A_DUTY: begin
                        duty_buf <= wr_data;
                        if (!buf_en) duty_act <= wr_data;
                    end
                    A_PER:  per_val <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && !per_hit) |=> $stable(duty_act)) else $error("buffered duty moved"); // R7

endmodule

// File: rtl/ppg_count.sv
module ppg_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] per_val,
    input  logic [CNT_W-1:0] duty_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             duty_hit,
    output logic             per_hit,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic cen;

    assign cen      = run && tick;
    assign per_hit  = cen && (cnt_q == per_val);
    assign duty_hit = cen && (cnt_q == duty_val) && (cnt_q != per_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= per_hit;
            if (!run)         cnt_q <= '0;
            else if (per_hit) cnt_q <= '0;
            else if (cen)     cnt_q <= cnt_q + ONE;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt_q == '0 || cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + ONE))
        else $error("counter jumped"); // R2
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0)) else $error("counter moved while stopped"); // R8

endmodule

// File: rtl/ppg_outff.sv
module ppg_outff (
    input  logic clk,
    input  logic rst_n,
    input  logic duty_hit,
    input  logic per_hit,
    input  logic tog_duty,
    input  logic tog_per,
    input  logic frc_lo,
    input  logic frc_hi,
    output logic out_q
);

    logic flip;

    assign flip = (duty_hit && tog_duty) || (per_hit && tog_per);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      out_q <= 1'b0;
        else if (frc_lo) out_q <= 1'b0;
        else if (frc_hi) out_q <= 1'b1;
        else if (flip)   out_q <= ~out_q;
    end

    AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(duty_hit || per_hit || frc_lo || frc_hi) |=> $stable(out_q)) else $error("spurious edge"); // R5
    AST_FRC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        frc_lo |=> !out_q) else $error("force low lost"); // R9
    AST_FRC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_hi && !frc_lo) |=> out_q) else $error("force high lost"); // R9

endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
    import ppg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              tick_div1,
    input  logic              tick_div4,
    input  logic              tick_div16,
    input  logic              ext_cnt,
    output logic              ppg_out,
    output logic              period_irq
);

    run_state_e       st_q, st_nxt;
    logic             run;
    logic             ctrl_wr;
    logic             buf_en, tog_duty, tog_per, frc_lo, frc_hi;
    tick_src_e        src;
    logic [CNT_W-1:0] duty_act, per_val, cnt;
    logic             tick, duty_hit, per_hit;

    assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_STOP: if (ctrl_wr && wr_data[0])  st_nxt = ST_RUN;
            ST_RUN:  if (ctrl_wr && !wr_data[0]) st_nxt = ST_STOP;
        endcase
    end

    always_comb begin
        run = (st_q == ST_RUN);
    end

    ppg_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .per_hit  (per_hit),
        .buf_en   (buf_en),
        .src      (src),
        .tog_duty (tog_duty),
        .tog_per  (tog_per),
        .frc_lo   (frc_lo),
        .frc_hi   (frc_hi),
        .duty_act (duty_act),
        .per_val  (per_val)
    );

    ppg_tick_sel u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .en_div1  (tick_div1),
        .en_div4  (tick_div4),
        .en_div16 (tick_div16),
        .ext_in   (ext_cnt),
        .tick     (tick)
    );

    ppg_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .per_val  (per_val),
        .duty_val (duty_act),
        .cnt_q    (cnt),
        .duty_hit (duty_hit),
        .per_hit  (per_hit),
        .irq_q    (period_irq)
    );

    ppg_outff u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .duty_hit (duty_hit),
        .per_hit  (per_hit),
        .tog_duty (tog_duty),
        .tog_per  (tog_per),
        .frc_lo   (frc_lo),
        .frc_hi   (frc_hi),
        .out_q    (ppg_out)
    );

    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_irq |-> (cnt == '0)) else $error("irq without clear"); // R3

endmodule

// File: tb/tb_ppg_timer.sv
module tb_ppg_timer;

    localparam int CLK_NS = 4;
    localparam int K_OUT = 0;
    localparam int K_IRQ = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        tick_div1 = 1'b1;
    logic        tick_div4 = 1'b0;
    logic        tick_div16 = 1'b0;
    logic        ext_cnt = 1'b0;
    logic        ppg_out, period_irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int dv = 0;
    int exp_lvl = 0;
    bit mon_on = 1'b1;
    logic prev_out = 1'b0;

    int    q_cyc[$];
    int    q_kind[$];
    int    q_lvl[$];
    string q_tag[$];

    ppg_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tick_div1(tick_div1), .tick_div4(tick_div4), .tick_div16(tick_div16),
        .ext_cnt(ext_cnt), .ppg_out(ppg_out), .period_irq(period_irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        dv = dv + 1;
        tick_div4  = (dv % 4) == 0;
        tick_div16 = (dv % 16) == 0;
        ext_cnt    = (dv % 6) < 3;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_ev(input int c, input int kind, input int lvl, input string tag);
        q_cyc.push_back(c);
        q_kind.push_back(kind);
        q_lvl.push_back(lvl);
        q_tag.push_back(tag);
    endtask

    task automatic take_ev(input int kind, input int lvl);
        int c, k, l;
        string t;
        if (q_cyc.size() == 0) begin
            check(1'b0, "R8 unexpected event", kind, -1);
        end else begin
            c = q_cyc.pop_front();
            k = q_kind.pop_front();
            l = q_lvl.pop_front();
            t = q_tag.pop_front();
            check(k == kind, {t, " event kind"}, kind, k);
            check(c == cyc, {t, " event cycle"}, cyc, c);
            if (kind == K_OUT) check(l == lvl, {t, " output level"}, lvl, l);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (ppg_out !== prev_out) take_ev(K_OUT, int'(ppg_out));
            if (period_irq) take_ev(K_IRQ, 1);
        end
        prev_out = ppg_out;
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // driver: expected events of nper periods after a run write captured at n0
    task automatic plan_run(input int n0, input int d, input int p, input int nper,
                            input bit td, input bit tp, input string dtag, output int last);
        for (int k = 0; k < nper; k++) begin
            int base = n0 + k * (p + 1);
            if (td && d < p) begin
                exp_lvl ^= 1;
                expect_ev(base + d + 1, K_OUT, exp_lvl, dtag);
            end
            if (tp) begin
                exp_lvl ^= 1;
                expect_ev(base + p + 1, K_OUT, exp_lvl, "R3");
            end
            expect_ev(base + p + 1, K_IRQ, 1, "R4");
            last = base + p + 1;
        end
    endtask

    task automatic stop_after(input int last);
        wait_until(last + 1);
        wr(3'd0, 16'h0000);  // R8 halt
        repeat (3) @(negedge clk);
    endtask

    task automatic simple_run(input int d, input int p, input int nper, input bit td,
                              input bit tp, input string dtag);
        int last;
        wr(3'd0, 16'h0000);
        wr(3'd3, d[15:0]);
        wr(3'd4, p[15:0]);
        wr(3'd0, 16'h0001);
        plan_run(cyc, d, p, nper, td, tp, dtag, last);
        stop_after(last);
    endtask

    task automatic irq_gap(input logic [1:0] sel, input int exp, input string tag);
        int t1, t2, guard;
        wr(3'd1, {14'd0, sel});          // R10 tick source
        wr(3'd0, 16'h0001);
        t1 = -1; t2 = -1; guard = 0;
        while (t2 < 0 && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (period_irq) begin
                if (t1 < 0) t1 = cyc; else t2 = cyc;
            end
        end
        check(t2 - t1 == exp, tag, t2 - t1, exp);
        wr(3'd0, 16'h0000);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n0, last;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ppg_out == 1'b0, "R1 output after reset", int'(ppg_out), 0);
        check(period_irq == 1'b0, "R1 irq after reset", int'(period_irq), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(ppg_out == 1'b0, "R1 idle output", int'(ppg_out), 0);

        // R5 R3 R4: both toggles, unbuffered, 3 periods
        wr(3'd2, 16'h0007);  // R10 tog both, force low
        simple_run(3, 9, 3, 1'b1, 1'b1, "R5");
        repeat (30) @(negedge clk);
        check(ppg_out == 1'(exp_lvl), "R8 level held while stopped", int'(ppg_out), exp_lvl);

        // R7 unbuffered duty write during run takes effect at once
        wr(3'd3, 16'd15);
        wr(3'd4, 16'd19);
        wr(3'd0, 16'h0001);
        n0 = cyc;
        plan_run(n0, 8, 19, 1, 1'b1, 1'b1, "R7", last);
        wait_until(n0 + 3);
        wr(3'd3, 16'd8);
        stop_after(last);

        // R7 buffered: write during period 0 applies from period 1
        wr(3'd3, 16'd2);
        wr(3'd4, 16'd7);
        wr(3'd0, 16'h0003);
        n0 = cyc;
        exp_lvl ^= 1; expect_ev(n0 + 3, K_OUT, exp_lvl, "R7");
        exp_lvl ^= 1; expect_ev(n0 + 8, K_OUT, exp_lvl, "R3");
        expect_ev(n0 + 8, K_IRQ, 1, "R4");
        plan_run(n0 + 8, 5, 7, 2, 1'b1, 1'b1, "R7", last);
        wr(3'd3, 16'd5);
        stop_after(last);

        // R6 duty equal to and above period
        simple_run(6, 6, 2, 1'b1, 1'b1, "R6");
        simple_run(9, 6, 2, 1'b1, 1'b1, "R6");

        // R5 duty toggle disabled
        wr(3'd2, 16'h0002);
        simple_run(2, 6, 2, 1'b0, 1'b1, "R5");
        check(q_cyc.size() == 0, "R5 all expected edges seen", q_cyc.size(), 0);

        // R9 force high and low while stopped
        mon_on = 1'b0;
        wr(3'd2, 16'h000B);
        check(ppg_out == 1'b1, "R9 R10 force high", int'(ppg_out), 1);
        wr(3'd2, 16'h000F);
        check(ppg_out == 1'b1, "R9 code 3 no change", int'(ppg_out), 1);
        wr(3'd2, 16'h0007);
        check(ppg_out == 1'b0, "R9 force low", int'(ppg_out), 0);

        // R2 tick sources, period value 4 -> 5 ticks
        wr(3'd3, 16'd1);
        wr(3'd4, 16'd4);
        irq_gap(2'd0, 5, "R2 div1 spacing");
        irq_gap(2'd1, 20, "R2 div4 spacing");
        irq_gap(2'd2, 80, "R2 div16 spacing");
        irq_gap(2'd3, 30, "R2 external edge spacing");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule